// File: doc/BRIEF.md
# Masked Bit-Test Executor

This unit runs the "test complement under mask" operation of an 8-bit microcontroller core. The core hands it an opcode byte and up to two operand bytes together with a start strobe. The unit fetches a destination byte and a mask byte from the core's register file through a read-only port. It forms the bitwise AND of the inverted destination with the mask and uses that value only to update the status flags. Nothing is written back, so both operands keep their values. A test for "all selected bits are one" therefore reads as a set zero flag.

Five opcodes select the addressing form:
- **0x62:** two working registers, packed into one byte.
- **0x63:** a working register with an indirect working-register source.
- **0x64:** two full register addresses.
- **0x65:** a full register destination with an indirect full-register source.
- **0x66:** a full register destination with an immediate mask.

The first form completes in its fourth cycle and the other four in their sixth cycle. Any other opcode is reported as illegal, and the flags stay as they were.

The register file has a synchronous read: data for the address driven in one cycle is returned in the next cycle. The flag byte lives inside the unit. The rest of the core can overwrite it through a load port.

Top module: `maskbit_test_unit`

## Requirements
- R1: On completion the zero flag (stat_q bit 6) is set when (NOT dst) AND mask equals 0, and is cleared otherwise.
- R2: On completion the sign flag (stat_q bit 5) takes bit 7 of (NOT dst) AND mask, and the overflow flag (stat_q bit 4) is cleared.
- R3: On completion the carry flag (bit 7), the decimal flag (bit 3), the half-carry flag (bit 2) and the spare bits 1:0 of stat_q keep their previous values.
- R4: Opcode 0x62 takes the destination register number from byte-1 bits 7:4 and the source register number from byte-1 bits 3:0, and reads both from file addresses 0..15. done is high in cycle 4, where cycle 1 is the cycle after the edge that accepts start.
- R5: Opcode 0x63 addresses its registers the same way as 0x62. It reads the source register and uses that byte as the file address of the mask. done is high in cycle 6.
- R6: Opcode 0x64 uses byte 1 as the destination address and byte 2 as the source address. Opcode 0x65 does the same but reads the mask indirectly through the source register. Opcode 0x66 uses byte 2 itself as the mask. All three have done high in cycle 6.
- R7: An opcode outside 0x62..0x66 makes illegal high for exactly cycle 1. busy and done stay low, and stat_q does not change.
- R8: A start while busy is high is ignored. It neither raises illegal nor alters the running operation's result or timing.
- R9: done is high for a single cycle, and stat_q takes its new value on the edge that ends that cycle. If stat_ld is high in that same cycle, it loses to the completion.
- R10: When the unit is not completing, stat_ld high loads stat_din into stat_q on the next edge.
- R11: After reset, busy, done and illegal are low and stat_q is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation with the presented bytes |
| instr_opc | input | 8 | Opcode byte |
| instr_b1 | input | 8 | First operand byte |
| instr_b2 | input | 8 | Second operand byte (3-byte forms) |
| rf_raddr | output | 8 | Register file read address |
| rf_rdata | input | 8 | Register file read data, one cycle after the address |
| stat_ld | input | 1 | Load the flag byte from stat_din |
| stat_din | input | 8 | Flag byte to load |
| stat_q | output | 8 | Flag byte: C=7, Z=6, S=5, V=4, D=3, H=2 |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Final cycle of an operation |
| illegal | output | 1 | Pulse for an unsupported opcode |

## Verification
After start is sampled, done must be low through cycle 3 (0x62) or cycle 5 (the other forms) and high in the next cycle. The bench checks done at every intermediate cycle rather than waiting for the flag. The flag byte is due one edge after the done cycle, so the bench samples stat_q on the falling edge that follows that edge. The illegal pulse is checked in cycle 1 and its absence, together with an unchanged stat_q, in cycle 2. Every sample is taken on the falling clock edge, midway between the edges that update the unit.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  typedef enum logic [2:0] {
    MD_WW,      // packed working registers
    MD_WWI,     // packed, indirect source
    MD_FF,      // full addresses
    MD_FFI,     // full addresses, indirect source
    MD_FIM,     // full destination, immediate mask
    MD_BAD
  } mode_e;

  localparam logic [7:0] OPC_WW  = 8'h62;
  localparam logic [7:0] OPC_WWI = 8'h63;
  localparam logic [7:0] OPC_FF  = 8'h64;
  localparam logic [7:0] OPC_FFI = 8'h65;
  localparam logic [7:0] OPC_FIM = 8'h66;

  localparam int unsigned FLG_C = 7;
  localparam int unsigned FLG_Z = 6;
  localparam int unsigned FLG_S = 5;
  localparam int unsigned FLG_V = 4;

endpackage

// File: rtl/mbt_decode.sv
module mbt_decode
  import mbt_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8
) (
  input  logic [DW-1:0] opc,
  input  logic [DW-1:0] b1,
  input  logic [DW-1:0] b2,
  output logic          legal,
  output logic          indir,
  output logic          imm,
  output logic          long_form,
  output logic [AW-1:0] dst_addr,
  output logic [AW-1:0] src_addr
);

  localparam int unsigned NIB = DW / 2;

  mode_e mode;

  always_comb begin
    case (opc)
      OPC_WW:  mode = MD_WW;
      OPC_WWI: mode = MD_WWI;
      OPC_FF:  mode = MD_FF;
      OPC_FFI: mode = MD_FFI;
      OPC_FIM: mode = MD_FIM;
      default: mode = MD_BAD;
    endcase
  end

  always_comb begin
    legal     = (mode != MD_BAD);
    indir     = (mode == MD_WWI) || (mode == MD_FFI);
    imm       = (mode == MD_FIM);
    long_form = (mode != MD_WW);
    if ((mode == MD_WW) || (mode == MD_WWI)) begin
      dst_addr = AW'(b1[DW-1:NIB]);
      src_addr = AW'(b1[NIB-1:0]);
    end else begin
      dst_addr = AW'(b1);
      src_addr = AW'(b2);
    end
  end

endmodule

// File: rtl/mbt_fetch.sv
module mbt_fetch #(
  parameter int unsigned DW        = 8,
  parameter int unsigned AW        = 8,
  parameter int unsigned SHORT_CYC = 4,
  parameter int unsigned LONG_CYC  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] dst_addr,
  input  logic [AW-1:0] src_addr,
  input  logic          indir,
  input  logic          imm,
  input  logic          long_form,
  input  logic [DW-1:0] imm_val,
  input  logic [DW-1:0] rf_rdata,
  output logic [AW-1:0] rf_raddr,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] dst_val,
  output logic [DW-1:0] mask_val
);

  localparam int unsigned CW = $clog2(LONG_CYC + 1);
  // fixed operand schedule (cycle numbers after start)
  localparam logic [CW-1:0] ST_DST_CAP = CW'(2);
  localparam logic [CW-1:0] ST_SRC_CAP = CW'(3);
  localparam logic [CW-1:0] ST_IND_ADR = CW'(4);
  localparam logic [CW-1:0] ST_IND_CAP = CW'(5);
  localparam logic [CW-1:0] LAST_S     = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LAST_L     = CW'(LONG_CYC);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] dadr_q, dadr_d, sadr_q, sadr_d;
  logic          indir_q, indir_d, imm_q, imm_d, long_q, long_d;
  logic [DW-1:0] dst_q, dst_d, src_q, src_d;
  logic          en;
  logic [CW-1:0] last;

  assign last = long_q ? LAST_L : LAST_S;
  assign en   = go | busy_q;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    dadr_d  = dadr_q;
    sadr_d  = sadr_q;
    indir_d = indir_q;
    imm_d   = imm_q;
    long_d  = long_q;
    dst_d   = dst_q;
    src_d   = src_q;
    if (!busy_q) begin
      if (go) begin
        busy_d  = 1'b1;
        cnt_d   = CW'(1);
        dadr_d  = dst_addr;
        sadr_d  = src_addr;
        indir_d = indir;
        imm_d   = imm;
        long_d  = long_form;
        src_d   = imm_val;
      end
    end else begin
      if (cnt_q == last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
      if (cnt_q == ST_DST_CAP) dst_d = rf_rdata;
      if ((cnt_q == ST_SRC_CAP) && !imm_q) src_d = rf_rdata;
      if ((cnt_q == ST_IND_CAP) && indir_q) src_d = rf_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      dadr_q  <= '0;
      sadr_q  <= '0;
      indir_q <= 1'b0;
      imm_q   <= 1'b0;
      long_q  <= 1'b0;
      dst_q   <= '0;
      src_q   <= '0;
    end else if (en) begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      dadr_q  <= dadr_d;
      sadr_q  <= sadr_d;
      indir_q <= indir_d;
      imm_q   <= imm_d;
      long_q  <= long_d;
      dst_q   <= dst_d;
      src_q   <= src_d;
    end
  end

  always_comb begin
    case (cnt_q)
      ST_DST_CAP: rf_raddr = sadr_q;
      ST_IND_ADR: rf_raddr = AW'(src_q);
      default:    rf_raddr = dadr_q;
    endcase
  end

  assign busy     = busy_q;
  assign done     = busy_q && (cnt_q == last);
  assign dst_val  = dst_q;
  assign mask_val = src_q;

endmodule

// File: rtl/mbt_flagcalc.sv
module mbt_flagcalc
  import mbt_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] dst_val,
  input  logic [DW-1:0] mask_val,
  input  logic [DW-1:0] stat_old,
  output logic [DW-1:0] stat_new
);

  logic [DW-1:0] probe;

  always_comb begin
    probe           = ~dst_val & mask_val;
    stat_new        = stat_old;
    stat_new[FLG_Z] = (probe == '0);
    stat_new[FLG_S] = probe[DW-1];
    stat_new[FLG_V] = 1'b0;
  end

endmodule

// File: rtl/maskbit_test_unit.sv
module maskbit_test_unit #(
  parameter int unsigned DW        = 8,
  parameter int unsigned AW        = 8,
  parameter int unsigned SHORT_CYC = 4,
  parameter int unsigned LONG_CYC  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] instr_opc,
  input  logic [DW-1:0] instr_b1,
  input  logic [DW-1:0] instr_b2,
  output logic [AW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  input  logic          stat_ld,
  input  logic [DW-1:0] stat_din,
  output logic [DW-1:0] stat_q,
  output logic          busy,
  output logic          done,
  output logic          illegal
);

  logic          rs_meta, rst_sync_n;
  logic          legal, indir, imm, long_form, go, bad;
  logic [AW-1:0] dst_addr, src_addr;
  logic [DW-1:0] dst_val, mask_val, stat_new, stat_d, stat_r;
  logic          stat_en, ill_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta    <= 1'b1;
      rst_sync_n <= rs_meta;
    end
  end

  mbt_decode #(.DW(DW), .AW(AW)) u_dec (
    .opc(instr_opc), .b1(instr_b1), .b2(instr_b2),
    .legal(legal), .indir(indir), .imm(imm), .long_form(long_form),
    .dst_addr(dst_addr), .src_addr(src_addr)
  );

  assign go  = start & ~busy & legal;
  assign bad = start & ~busy & ~legal;

  mbt_fetch #(.DW(DW), .AW(AW), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_fetch (
    .clk(clk), .rst_n(rst_sync_n), .go(go),
    .dst_addr(dst_addr), .src_addr(src_addr), .indir(indir), .imm(imm),
    .long_form(long_form), .imm_val(instr_b2), .rf_rdata(rf_rdata),
    .rf_raddr(rf_raddr), .busy(busy), .done(done),
    .dst_val(dst_val), .mask_val(mask_val)
  );

  mbt_flagcalc #(.DW(DW)) u_flag (
    .dst_val(dst_val), .mask_val(mask_val), .stat_old(stat_r), .stat_new(stat_new)
  );

  always_comb begin
    stat_en = done | stat_ld;
    stat_d  = done ? stat_new : stat_din;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stat_r <= '0;
    end else if (stat_en) begin
      stat_r <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ill_q <= 1'b0;
    end else begin
      ill_q <= bad;
    end
  end

  assign stat_q  = stat_r;
  assign illegal = ill_q;

endmodule

// File: rtl/mbt_checker.sv
module mbt_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stat_ld,
  input logic          busy,
  input logic          done,
  input logic          illegal,
  input logic [DW-1:0] stat_q
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R9

  AST_KEEP_CDH: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (stat_q[7] == $past(stat_q[7])) && (stat_q[3:0] == $past(stat_q[3:0]))); // R3

  AST_V_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !stat_q[4]); // R2

  AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !done)); // R7

  AST_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ((stat_q == $past(stat_q)) || $past(stat_ld))); // R7

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R8

endmodule

bind maskbit_test_unit mbt_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .stat_ld(stat_ld), .busy(busy),
  .done(done), .illegal(illegal), .stat_q(stat_q)
);

// File: tb/maskbit_test_unit_tb_top.sv
module maskbit_test_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] instr_opc, instr_b1, instr_b2;
  logic [7:0] rf_raddr, rf_rdata;
  logic       stat_ld;
  logic [7:0] stat_din, stat_q;
  logic       busy, done, illegal;

  logic [7:0] mem [256];
  int         errs = 0;
  int         checks = 0;
  int         wd = 0;

  always #4 clk = ~clk;  // 125 MHz

  maskbit_test_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .instr_opc(instr_opc), .instr_b1(instr_b1), .instr_b2(instr_b2),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .stat_ld(stat_ld), .stat_din(stat_din), .stat_q(stat_q),
    .busy(busy), .done(done), .illegal(illegal)
  );

  always @(posedge clk) rf_rdata <= mem[rf_raddr];

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int cyc_of(input logic [7:0] opc);
    return (opc == 8'h62) ? 4 : 6;
  endfunction

  function automatic logic [7:0] model(input logic [7:0] opc, b1, b2, old);
    logic [7:0] d, m, r;
    if (opc == 8'h62 || opc == 8'h63) begin
      d = mem[{4'h0, b1[7:4]}];
      m = mem[{4'h0, b1[3:0]}];
    end else begin
      d = mem[b1];
      m = (opc == 8'h66) ? b2 : mem[b2];
    end
    if (opc == 8'h63 || opc == 8'h65) m = mem[m];
    r = ~d & m;
    return {old[7], (r == 8'h00), r[7], 1'b0, old[3:0]};
  endfunction

  // intrude: start again while busy (R8) and stat_ld during done (R9)
  task automatic exec(input logic [7:0] opc, b1, b2, input bit intrude, input string tag);
    logic [7:0] old, exp;
    int n;
    old = stat_q;
    exp = model(opc, b1, b2, old);
    n   = cyc_of(opc);
    instr_opc = opc; instr_b1 = b1; instr_b2 = b2; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= n; k++) begin
      if (intrude && k == 2) begin start = 1'b1; instr_opc = 8'h61; end
      if (intrude && k == 3) begin instr_opc = 8'h66; instr_b2 = ~b2; end
      if (k == n) begin
        start = 1'b0;
        if (intrude) begin stat_ld = 1'b1; stat_din = 8'h5A; end
      end
      chk(done == (k == n), {tag, " done timing"}, done, (k == n));
      if (intrude && k >= 3) chk(illegal == 1'b0, "R8 start while busy", illegal, 0);
      if (k < n) @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    stat_ld = 1'b0;
    chk(stat_q == exp, {tag, " flags"}, stat_q, exp);
    chk(busy == 1'b0 && done == 1'b0, {tag, " idle after done"}, {busy, done}, 0);
  endtask

  task automatic bad_op(input logic [7:0] opc);
    logic [7:0] old;
    old = stat_q;
    instr_opc = opc; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(illegal == 1'b1 && busy == 1'b0, "R7 illegal pulse", {illegal, busy}, 2'b10);
    @(posedge clk);
    @(negedge clk);
    chk(illegal == 1'b0 && done == 1'b0, "R7 pulse ends", {illegal, done}, 0);
    chk(stat_q == old, "R7 flags unchanged", stat_q, old);
  endtask

  task automatic load(input logic [7:0] v);
    stat_ld = 1'b1; stat_din = v;
    @(posedge clk);
    @(negedge clk);
    stat_ld = 1'b0;
    chk(stat_q == v, "R10 flag load", stat_q, v);
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    rst_n = 1'b0; start = 1'b0; stat_ld = 1'b0; stat_din = '0;
    instr_opc = '0; instr_b1 = '0; instr_b2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && illegal == 0, "R11 reset outputs", {busy, done, illegal}, 0);
    chk(stat_q == 8'h00, "R11 reset flags", stat_q, 0);

    // R1 R4: all tested bits one -> Z set
    mem[0] = 8'hC7; mem[1] = 8'h02;
    load(8'hFF);
    exec(8'h62, 8'h01, 8'h00, 1'b0, "R1 R4 zero result");
    chk(stat_q[6] == 1'b1, "R1 Z set", stat_q[6], 1);
    // R1 R6 immediate: nonzero
    mem[0] = 8'h2B;
    exec(8'h66, 8'h00, 8'h34, 1'b0, "R1 R6 immediate");
    chk(stat_q[6] == 1'b0, "R1 Z clear", stat_q[6], 0);
    // R2: sign from bit 7
    mem[8'h10] = 8'h00; mem[8'h11] = 8'h80;
    load(8'h10);
    exec(8'h64, 8'h10, 8'h11, 1'b0, "R2 R6 direct");
    chk(stat_q[5] == 1'b1 && stat_q[4] == 1'b0, "R2 S set V clear", stat_q[5:4], 2'b10);
    // R5 indirect working, R6 indirect full
    mem[2] = 8'h40; mem[3] = 8'h20; mem[8'h20] = 8'h0F;
    exec(8'h63, 8'h23, 8'h00, 1'b0, "R5 indirect packed");
    exec(8'h65, 8'h02, 8'h03, 1'b0, "R6 indirect full");
    // R3 preserved bits
    load(8'h8F);
    exec(8'h64, 8'h05, 8'h06, 1'b0, "R3 keep C D H");
    chk(stat_q[7] == 1'b1 && stat_q[3:0] == 4'hF, "R3 preserved", {stat_q[7], stat_q[3:0]}, 5'h1F);
    // R8 R9 intrusion
    exec(8'h62, 8'h45, 8'h00, 1'b1, "R8 R9 short");
    exec(8'h65, 8'h33, 8'h44, 1'b1, "R8 R9 long");
    bad_op(8'h61);
    bad_op(8'h67);
    bad_op(8'h00);

    for (int i = 0; i < 60; i++) begin
      if (i % 7 == 0) load(8'($urandom));
      if (i % 11 == 5) begin
        r = 8'($urandom);
        if (r >= 8'h62 && r <= 8'h66) r = r + 8'h08;
        bad_op(r);
      end
      exec(8'h62 + 8'($urandom % 5), 8'($urandom), 8'($urandom), (i % 9 == 4), "R1 R2 R3 random");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule